// File: doc/BRIEF.md
# Triple-Redundant Signed Multiply-Accumulator

This block is a signed multiply-accumulate datapath in which every piece of arithmetic and every state register exists three times. Each of the three lanes has its own multiplier, adder and accumulator register. Each lane also has its own majority voter, placed directly after the accumulator registers. Every lane's feedback path reads the output of its own voter and never its own raw register. A bit flipped in one lane's accumulator is therefore outvoted by the other two lanes on the following clock edge. The error cannot circulate in the loop.

The operands and the control inputs are shared and reach all three lanes unchanged. The lanes rejoin in a single output register, whose input is a bitwise majority of the three lane accumulators. The accumulation loop is built in general logic, so the voters can sit inside it.

For test, an injection port flips one chosen bit of one chosen lane's accumulator on a clock edge. A mismatch flag reports any cycle in which the three lane accumulators disagree.

Top module: `tmr_mac`

## Requirements
- R1: While `rst_n` is low at a rising edge, all lane accumulators and `result` are loaded with zero, and after that edge `mismatch` is 0.
- R2: At a rising edge with `rst_n` high, `clear` low and `valid` high, the accumulator becomes its old value plus the signed product `op_a*op_b`, sign-extended to ACC_W bits and wrapped modulo 2^ACC_W.
- R3: At a rising edge with `clear` and `valid` both low, the accumulator keeps its value, whatever the operands are.
- R4: `clear` high at a rising edge loads zero into all three lane accumulators and takes priority over `valid`.
- R5: With `inj_en` high at a rising edge, bit `inj_bit` of lane `inj_lane` is inverted after that edge's update. Lanes are numbered 0, 1 and 2. A lane code of 3, or a bit index of ACC_W or above, flips nothing.
- R6: `mismatch` is high in exactly those cycles in which the three lane accumulators are not all equal. After an effective injection it is high for the following cycle.
- R7: Each lane's next state is computed from its own majority-voted copy of the accumulators. One edge after a single-lane upset, all three lanes are equal again and `mismatch` is 0 unless a new fault is injected.
- R8: `result` shows, one edge after each accumulator update, the value a plain non-redundant accumulator would hold. This holds on every cycle, even when a single-lane fault is injected on every edge.
- R9: The vote is bitwise: each result bit is `(x&y)|(y&z)|(z&x)` over the three lanes. Flips in the most and least significant bits are corrected the same way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| clear | input | 1 | Load zero into the accumulators; overrides valid |
| valid | input | 1 | Add op_a*op_b to the accumulator |
| op_a | input | W | Signed two's complement multiplicand |
| op_b | input | W | Signed two's complement multiplier |
| inj_en | input | 1 | Fault injection enable for this edge |
| inj_lane | input | 2 | Lane to corrupt (0..2; 3 = none) |
| inj_bit | input | $clog2(ACC_W) | Bit index to invert |
| result | output | ACC_W | Voted, registered accumulator value |
| mismatch | output | 1 | The three lane accumulators differ this cycle |

## Verification
A lane that keeps a wrong value does not show on `result`, because two good lanes outvote it. Such a lane is seen at the ports only through `mismatch`. The flag must rise for exactly the one cycle after an injection and fall on the next edge. If the flag stays high, the feedback is not voted. A fault that reaches `result` means the vote has been bypassed or is wrong. That error shows one edge after the faulty update and then stays in the sum. The bench keeps a plain accumulator and expects an exact match on every cycle.

// File: rtl/tmr_mac_pkg.sv
// Package: shared constants and the bitwise majority primitive for the
// triple-redundant accumulator. Assumes exactly three lanes.
package tmr_mac_pkg;
    localparam int LANES = 3;
    typedef logic [1:0] lane_sel_t;

    // Two-of-three majority of single bits.
    function automatic logic maj_bit(input logic x, input logic y, input logic z);
        return (x & y) | (y & z) | (z & x);
    endfunction
endpackage

// File: rtl/tmr_maj_voter.sv
// Bitwise two-of-three voter. Purely combinational; one instance per
// consumer so that a transient in one voter affects one lane only.
module tmr_maj_voter #(
    parameter int WIDTH = 24
) (
    input  logic [WIDTH-1:0] in_x,
    input  logic [WIDTH-1:0] in_y,
    input  logic [WIDTH-1:0] in_z,
    output logic [WIDTH-1:0] voted
);
    import tmr_mac_pkg::*;

    // One majority gate per bit position.
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign voted[i] = maj_bit(in_x[i], in_y[i], in_z[i]);
    end
endmodule

// File: rtl/tmr_mac_lane.sv
// One lane of the redundant accumulator: a signed multiplier, an adder and
// an accumulator register. The running sum comes from this lane's voter
// (fb_acc), never from its own register, so a bad register is repaired on
// the next edge. flip_en/flip_bit invert one stored bit (test only).
// Assumes ACC_W >= 2*W.
module tmr_mac_lane #(
    parameter int W     = 8,
    parameter int ACC_W = 2*W+8,
    parameter int IDX_W = $clog2(ACC_W)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear,
    input  logic                    valid,
    input  logic signed [W-1:0]     op_a,
    input  logic signed [W-1:0]     op_b,
    input  logic [ACC_W-1:0]        fb_acc,
    input  logic                    flip_en,
    input  logic [IDX_W-1:0]        flip_bit,
    output logic [ACC_W-1:0]        acc_q
);
    localparam int PROD_W = 2*W;

    logic signed [PROD_W-1:0] prod;
    logic signed [ACC_W-1:0]  prod_ext;
    logic [ACC_W-1:0]         sum;
    logic [ACC_W-1:0]         acc_d;
    logic [ACC_W-1:0]         flip_mask;

    // Signed product, sign-extended to accumulator width.
    always_comb begin
        prod     = op_a * op_b;
        prod_ext = ACC_W'(prod);
    end

    // Adder fed by the voted feedback value.
    assign sum = fb_acc + ACC_W'(prod_ext);

    // Next-state selection: clear beats valid, otherwise hold voted value.
    always_comb begin
        if (clear)      acc_d = '0;
        else if (valid) acc_d = sum;
        else            acc_d = fb_acc;
    end

    // Injection mask; an index past the top bit shifts out to zero.
    always_comb begin
        flip_mask = '0;
        if (flip_en) flip_mask = ACC_W'(1) << flip_bit;
    end

    // Accumulator register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d ^ flip_mask;
    end
endmodule

// File: rtl/tmr_mac_merge.sv
// Output stage: votes the three raw lane accumulators into one value,
// registers it and compares the lanes for the disagreement flag. The flag is
// combinational on the lane registers, so it is valid in the same cycle.
module tmr_mac_merge #(
    parameter int ACC_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ACC_W-1:0] lane0,
    input  logic [ACC_W-1:0] lane1,
    input  logic [ACC_W-1:0] lane2,
    output logic [ACC_W-1:0] result,
    output logic             mismatch
);
    logic [ACC_W-1:0] out_vote;

    tmr_maj_voter #(.WIDTH(ACC_W)) out_voter_i (
        .in_x  (lane0),
        .in_y  (lane1),
        .in_z  (lane2),
        .voted (out_vote)
    );

    // Single output register fed by the majority of the lanes.
    always_ff @(posedge clk) begin
        if (!rst_n) result <= '0;
        else        result <= out_vote;
    end

    // Disagreement detector across the three lanes.
    always_comb begin
        mismatch = (lane0 != lane1) || (lane1 != lane2);
    end
endmodule

// File: rtl/tmr_mac.sv
// Top of the triple-redundant multiply-accumulator. Three lanes share the
// operand and control inputs; three voters (one per lane) close each
// feedback loop; a fourth voter feeds the single output register.
// Assumes ACC_W >= 2*W and a fault-free clock tree.
module tmr_mac
    import tmr_mac_pkg::*;
#(
    parameter int W     = 8,
    parameter int ACC_W = 2*W+8,
    localparam int IDX_W = $clog2(ACC_W)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear,
    input  logic                valid,
    input  logic [W-1:0]        op_a,
    input  logic [W-1:0]        op_b,
    input  logic                inj_en,
    input  logic [1:0]          inj_lane,
    input  logic [IDX_W-1:0]    inj_bit,
    output logic [ACC_W-1:0]    result,
    output logic                mismatch
);
    logic [ACC_W-1:0] lane_acc [LANES];
    logic [ACC_W-1:0] lane_fb  [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic lane_flip;

        // Per-lane decode of the injection target.
        assign lane_flip = inj_en && (inj_lane == lane_sel_t'(g));

        // This lane's own voter inside its feedback loop.
        tmr_maj_voter #(.WIDTH(ACC_W)) fb_voter_i (
            .in_x  (lane_acc[0]),
            .in_y  (lane_acc[1]),
            .in_z  (lane_acc[2]),
            .voted (lane_fb[g])
        );

        tmr_mac_lane #(.W(W), .ACC_W(ACC_W), .IDX_W(IDX_W)) lane_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .clear    (clear),
            .valid    (valid),
            .op_a     (op_a),
            .op_b     (op_b),
            .fb_acc   (lane_fb[g]),
            .flip_en  (lane_flip),
            .flip_bit (inj_bit),
            .acc_q    (lane_acc[g])
        );
    end

    tmr_mac_merge #(.ACC_W(ACC_W)) merge_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .lane0    (lane_acc[0]),
        .lane1    (lane_acc[1]),
        .lane2    (lane_acc[2]),
        .result   (result),
        .mismatch (mismatch)
    );
endmodule

// File: rtl/tmr_mac_chk.sv
// Checker for tmr_mac, bound to every instance. Watches the lane
// registers and the per-lane voted feedback.
module tmr_mac_chk #(
    parameter int ACC_W = 24,
    localparam int IDX_W = $clog2(ACC_W)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clear,
    input logic             valid,
    input logic             inj_en,
    input logic [1:0]       inj_lane,
    input logic [IDX_W-1:0] inj_bit,
    input logic [ACC_W-1:0] result,
    input logic             mismatch,
    input logic [ACC_W-1:0] acc0,
    input logic [ACC_W-1:0] acc1,
    input logic [ACC_W-1:0] acc2,
    input logic [ACC_W-1:0] fb0
);
    logic hit;
    assign hit = inj_en && (inj_lane != 2'd3) && (32'(inj_bit) < ACC_W);

    // R1
    reset_zero_chk: assert property (@(posedge clk)
        !rst_n |=> (result == '0) && !mismatch);

    // R4
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear && !inj_en |=> (acc0 == '0) && (acc1 == '0) && (acc2 == '0));

    // R3
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clear && !valid && !hit |=> acc0 == $past(fb0));

    // R6
    flag_after_inject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> mismatch);

    // R7
    repair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> !mismatch && (acc0 == acc1) && (acc1 == acc2));
endmodule

bind tmr_mac tmr_mac_chk #(.ACC_W(ACC_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (clear),
    .valid    (valid),
    .inj_en   (inj_en),
    .inj_lane (inj_lane),
    .inj_bit  (inj_bit),
    .result   (result),
    .mismatch (mismatch),
    .acc0     (lane_acc[0]),
    .acc1     (lane_acc[1]),
    .acc2     (lane_acc[2]),
    .fb0      (lane_fb[0])
);

// File: tb/tmr_mac_tb_top.sv
// Bench: behavioural single accumulator model, compared on every negedge.
module tmr_mac_tb_top;
    localparam int W     = 8;
    localparam int ACC_W = 2*W+8;
    localparam int IDX_W = $clog2(ACC_W);
    localparam longint MASK = (64'd1 << ACC_W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clear = 1'b0, valid = 1'b0, inj_en = 1'b0;
    logic [W-1:0] op_a = '0, op_b = '0;
    logic [1:0] inj_lane = '0;
    logic [IDX_W-1:0] inj_bit = '0;
    logic [ACC_W-1:0] result;
    logic mismatch;

    int vectors = 0;
    int fails = 0;
    bit done = 0;
    string tag = "R1";

    longint exp_acc = 0, exp_res = 0;
    bit exp_mm = 0;

    always #10 clk = ~clk;

    tmr_mac #(.W(W), .ACC_W(ACC_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .clear(clear), .valid(valid),
        .op_a(op_a), .op_b(op_b), .inj_en(inj_en), .inj_lane(inj_lane),
        .inj_bit(inj_bit), .result(result), .mismatch(mismatch)
    );

    // Reference: a plain accumulator and the expected flag.
    always @(posedge clk) begin
        if (!rst_n) begin
            exp_acc <= 0; exp_res <= 0; exp_mm <= 0;
        end else begin
            exp_res <= exp_acc;
            if (clear)      exp_acc <= 0;
            else if (valid) exp_acc <= (exp_acc + longint'($signed(op_a)) * longint'($signed(op_b))) & MASK;
            exp_mm <= inj_en && (inj_lane != 2'd3) && (int'(inj_bit) < ACC_W);
        end
    end

    // Compare away from the active edge.
    always @(negedge clk) begin
        if (!done) begin
            vectors++;
            if (longint'(result) != exp_res) begin
                fails++;
                $display("FAIL %s result got %h expected %h", tag, result, exp_res[ACC_W-1:0]);
            end
            if (mismatch !== exp_mm) begin
                fails++;
                $display("FAIL %s mismatch got %b expected %b", tag, mismatch, exp_mm);
            end
        end
    end

    task automatic step(input bit c, input bit v, input logic [W-1:0] a, input logic [W-1:0] b,
                        input bit ie, input logic [1:0] il, input logic [IDX_W-1:0] ib);
        @(negedge clk);
        clear = c; valid = v; op_a = a; op_b = b;
        inj_en = ie; inj_lane = il; inj_bit = ib;
    endtask

    initial begin
        // R1: reset state, with injection attempted during reset
        tag = "R1";
        step(0, 1, 8'd5, 8'd5, 1, 2'd1, 5'd3);
        repeat (3) step(0, 1, 8'd5, 8'd5, 1, 2'd1, 5'd3);
        rst_n = 1'b1;
        step(0, 0, 0, 0, 0, 0, 0);
        // R2: signed products including extremes
        tag = "R2";
        step(0, 1, 8'h80, 8'h80, 0, 0, 0);
        step(0, 1, 8'h7f, 8'h80, 0, 0, 0);
        step(0, 1, 8'hff, 8'h01, 0, 0, 0);
        for (int i = 0; i < 20; i++) step(0, 1, 8'($urandom), 8'($urandom), 0, 0, 0);
        // R3: valid low holds despite changing operands
        tag = "R3";
        for (int i = 0; i < 6; i++) step(0, 0, 8'($urandom), 8'($urandom), 0, 0, 0);
        // R4: clear beats valid
        tag = "R4";
        step(1, 1, 8'd100, 8'd100, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0, 0);
        // R2: wrap-around modulo 2^ACC_W
        tag = "R2";
        for (int i = 0; i < 1100; i++) step(0, 1, 8'h7f, 8'h7f, 0, 0, 0);
        // R5: each lane, plus codes that must flip nothing
        tag = "R5";
        for (int l = 0; l < 4; l++) step(0, 1, 8'd3, 8'hfd, 1, 2'(l), 5'd7);
        step(0, 1, 8'd9, 8'd9, 1, 2'd2, 5'd30);
        step(0, 0, 0, 0, 0, 0, 0);
        // R6 and R7: isolated fault, flag high one cycle then cleared
        tag = "R6";
        step(0, 0, 0, 0, 1, 2'd0, 5'd0);
        tag = "R7";
        step(0, 0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0, 0);
        // R4: clear together with injection
        tag = "R4";
        step(1, 0, 0, 0, 1, 2'd1, 5'd4);
        step(0, 0, 0, 0, 0, 0, 0);
        // R9: top and bottom bit flips in every lane
        tag = "R9";
        for (int l = 0; l < 3; l++) begin
            step(0, 1, 8'h81, 8'h11, 1, 2'(l), 5'(ACC_W-1));
            step(0, 1, 8'h22, 8'hf0, 1, 2'(l), 5'd0);
        end
        // R8: random traffic with a fault injected on every edge
        tag = "R8";
        for (int i = 0; i < 3000; i++)
            step(($urandom % 64) == 0, 1'($urandom), 8'($urandom), 8'($urandom),
                 1, 2'($urandom), 5'($urandom));
        step(0, 0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0, 0);
        @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule